// File: doc/BRIEF.md
# Pad Delay Configuration Register Bank

This block is the software-visible register bank of a pad delay controller. A 32-bit read/write bus with byte offsets reaches three groups of registers. The first is a global lock word that opens only when a 16-bit key is written. The second is a set of read-only calibration words that show the reference clock period and the coarse and fine ring counts; these values arrive on input ports. The third is a table of three 32-bit words per pin.

The first word of each pin carries that pin's coarse and fine delay element counts. The block drives them out as flat per-pin buses, which the delay lines consume directly.

A write to a pin word only lands when the bank is open and the word itself carries the correct 6-bit signature. A write that fails either test leaves the stored word untouched and raises a sticky error flag. Software reads that flag back through the lock word. The analog delay lines and the calibration measurement sit outside this block.

Top module: `dlyreg_bank`

## Requirements
- R1: After reset the bank is locked, the sticky error flag is clear, every stored pin word is zero (so every `pin_coarse` and `pin_fine` field is zero), and a read of offset 0x2C returns 0x0000AAAB.
- R2: A write to offset 0x2C with bits 15:0 equal to 0xAAAA opens the bank, and with bits 15:0 equal to 0xAAAB locks it; bits 31:16 of that write are ignored. A read of 0x2C returns 0xAAAA in bits 15:0 while open and 0xAAAB while locked.
- R3: A write to offset 0x2C whose bits 15:0 are neither key leaves the lock state unchanged.
- R4: Pin p (0 to NUM_PINS-1) owns three words at offsets 0x30 + 12*p + 4*s for s = 0, 1, 2; with the default NUM_PINS of 276 the last word sits at 0xD1C. An accepted write stores all 32 bits, and a read returns the stored word.
- R5: A write to a pin word is accepted only when the bank is open and wdata bits 17:12 equal 0x29; otherwise the stored word does not change.
- R6: A rejected pin-word write sets a sticky error flag, read as bit 31 of offset 0x2C (bits 30:16 read zero); the flag stays set until reset.
- R7: `pin_coarse[5p+4:5p]` equals bits 9:5 and `pin_fine[5p+4:5p]` equals bits 4:0 of pin p's word at s = 0; bit 10 of that word is a stored lock bit that does not affect the outputs. The outputs change on the clock edge that accepts the write.
- R8: Offset 0x14 reads {16'h0, period}; 0x18 reads {coarse delay count, coarse reference count}; 0x1C reads {fine delay count, fine reference count}. Writes to these offsets change nothing and raise no error.
- R9: Offsets 0x00-0x10, 0x20-0x28, offsets beyond the last pin word, and offsets not a multiple of 4 read as zero. Writes to them change no state and raise no error.
- R10: Read data is registered: a read issued with `rd_en` on a clock edge shows on `rdata` after that edge, and `rdata` holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cal_ref_period | input | 16 | Measured reference clock period |
| cal_coarse_delay | input | 16 | Coarse ring delay count |
| cal_coarse_ref | input | 16 | Coarse ring reference count |
| cal_fine_delay | input | 16 | Fine ring delay count |
| cal_fine_ref | input | 16 | Fine ring reference count |
| pin_coarse | output | 5*NUM_PINS | Coarse element count, 5 bits per pin |
| pin_fine | output | 5*NUM_PINS | Fine element count, 5 bits per pin |

## Verification
The assertions assume that `rst_n` is low before the first clock edge. They also assume that `wr_en` and `rd_en` are never both high in one cycle, so a rejected pin write always coincides with a stable lock state. The bench drives every access from the falling edge as a single-cycle strobe and never overlaps a read with a write. It sweeps every word of every pin at the default size and probes each reserved and misaligned offset. Calibration inputs change only between accesses.

// File: rtl/dlyreg_pkg.sv
package dlyreg_pkg;
   localparam int unsigned BUS_W        = 32;
   localparam int unsigned OFF_REFCLK   = 'h14;
   localparam int unsigned OFF_CRS_CAL  = 'h18;
   localparam int unsigned OFF_FIN_CAL  = 'h1C;
   localparam int unsigned OFF_LOCK     = 'h2C;
   localparam int unsigned OFF_PIN_BASE = 'h30;
   localparam int unsigned WORDS_PER_PIN = 3;
   localparam int unsigned WORD_BYTES   = 4;

   localparam logic [15:0] KEY_OPEN = 16'hAAAA;
   localparam logic [15:0] KEY_SHUT = 16'hAAAB;

   localparam int unsigned SIG_LSB    = 12;
   localparam int unsigned SIG_W      = 6;
   localparam logic [SIG_W-1:0] SIG_VAL = 6'h29;
   localparam int unsigned CNT_W      = 5;
   localparam int unsigned COARSE_LSB = 5;
   localparam int unsigned FINE_LSB   = 0;
   localparam int unsigned ERR_BIT    = 31;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_LOCK,
      ACC_REFCLK,
      ACC_CRS,
      ACC_FIN,
      ACC_PIN
   } acc_kind_e;
endpackage

// File: rtl/dlyreg_decode.sv
module dlyreg_decode
   import dlyreg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_WORDS = 828,
   localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind,
   output logic [IDX_W-1:0]  word_idx
);
   localparam int unsigned PIN_LAST = OFF_PIN_BASE + WORD_BYTES*NUM_WORDS - WORD_BYTES;

   logic [31:0] a32;
   logic [31:0] rel;

   assign a32 = 32'(addr);
   assign rel = a32 - 32'(OFF_PIN_BASE);

   always_comb begin
      kind     = ACC_NONE;
      word_idx = IDX_W'(rel >> 2);
      if (addr[1:0] == 2'b00) begin
         if (a32 == 32'(OFF_LOCK))         kind = ACC_LOCK;
         else if (a32 == 32'(OFF_REFCLK))  kind = ACC_REFCLK;
         else if (a32 == 32'(OFF_CRS_CAL)) kind = ACC_CRS;
         else if (a32 == 32'(OFF_FIN_CAL)) kind = ACC_FIN;
         else if (a32 >= 32'(OFF_PIN_BASE) && a32 <= 32'(PIN_LAST)) kind = ACC_PIN;
      end
   end
endmodule

// File: rtl/dlyreg_gate.sv
module dlyreg_gate
   import dlyreg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_wr,
   input  logic [15:0]      key,
   input  logic             pin_wr,
   input  logic [SIG_W-1:0] sig,
   output logic             lock_open,
   output logic             err_q,
   output logic             pin_accept
);
   logic sig_ok;

   assign sig_ok     = (sig == SIG_VAL);
   assign pin_accept = pin_wr & lock_open & sig_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_open <= 1'b0;
      end else if (lock_wr) begin
         if (key == KEY_OPEN)      lock_open <= 1'b1;
         else if (key == KEY_SHUT) lock_open <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   err_q <= 1'b0;
      else if (pin_wr && !pin_accept) err_q <= 1'b1;
   end
endmodule

// File: rtl/dlyreg_words.sv
module dlyreg_words
   import dlyreg_pkg::*;
#(
   parameter int unsigned NUM_PINS = 276,
   localparam int unsigned NUM_WORDS = NUM_PINS * WORDS_PER_PIN,
   localparam int unsigned IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [IDX_W-1:0]          widx,
   input  logic [BUS_W-1:0]          wdata,
   input  logic [IDX_W-1:0]          ridx,
   output logic [BUS_W-1:0]          rword,
   output logic [NUM_PINS*CNT_W-1:0] pin_coarse,
   output logic [NUM_PINS*CNT_W-1:0] pin_fine
);
   logic [BUS_W-1:0] word_q [NUM_WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WORDS; i++) word_q[i] <= '0;
      end else if (we) begin
         word_q[widx] <= wdata;
      end
   end

   always_comb begin
      rword = '0;
      if (32'(ridx) < NUM_WORDS) rword = word_q[ridx];
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pin_coarse[p*CNT_W +: CNT_W] = word_q[p*WORDS_PER_PIN][COARSE_LSB +: CNT_W];
      assign pin_fine[p*CNT_W +: CNT_W]   = word_q[p*WORDS_PER_PIN][FINE_LSB +: CNT_W];
   end
endmodule

// File: rtl/dlyreg_bank.sv
module dlyreg_bank
   import dlyreg_pkg::*;
#(
   parameter int unsigned NUM_PINS = 276,
   parameter int unsigned ADDR_W   = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      rd_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [31:0]               wdata,
   output logic [31:0]               rdata,
   input  logic [15:0]               cal_ref_period,
   input  logic [15:0]               cal_coarse_delay,
   input  logic [15:0]               cal_coarse_ref,
   input  logic [15:0]               cal_fine_delay,
   input  logic [15:0]               cal_fine_ref,
   output logic [NUM_PINS*5-1:0]     pin_coarse,
   output logic [NUM_PINS*5-1:0]     pin_fine
);
   localparam int unsigned NUM_WORDS = NUM_PINS * WORDS_PER_PIN;
   localparam int unsigned IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam longint unsigned TOP_OFF = OFF_PIN_BASE + WORD_BYTES*NUM_WORDS - WORD_BYTES;

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("dlyreg_bank: NUM_PINS must be at least 1");
   end
   if (ADDR_W < 6 || ADDR_W > 31) begin : g_bad_aw
      $error("dlyreg_bank: ADDR_W out of range");
   end
   if (TOP_OFF >= (64'd1 << ADDR_W)) begin : g_bad_span
      $error("dlyreg_bank: pin table does not fit in ADDR_W");
   end
   if (CNT_W != 5) begin : g_bad_cnt
      $error("dlyreg_bank: count field width must match port slicing");
   end

   acc_kind_e        kind;
   logic [IDX_W-1:0] word_idx;
   logic             lock_open;
   logic             err_q;
   logic             pin_accept;
   logic [31:0]      rword;
   logic [31:0]      rdata_q;

   dlyreg_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_WORDS (NUM_WORDS)
   ) u_decode (
      .addr     (addr),
      .kind     (kind),
      .word_idx (word_idx)
   );

   dlyreg_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock_wr    (wr_en && kind == ACC_LOCK),
      .key        (wdata[15:0]),
      .pin_wr     (wr_en && kind == ACC_PIN),
      .sig        (wdata[SIG_LSB +: SIG_W]),
      .lock_open  (lock_open),
      .err_q      (err_q),
      .pin_accept (pin_accept)
   );

   dlyreg_words #(
      .NUM_PINS (NUM_PINS)
   ) u_words (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (pin_accept),
      .widx       (word_idx),
      .wdata      (wdata),
      .ridx       (word_idx),
      .rword      (rword),
      .pin_coarse (pin_coarse),
      .pin_fine   (pin_fine)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         unique case (kind)
            ACC_LOCK:   rdata_q <= {err_q, 15'd0, (lock_open ? KEY_OPEN : KEY_SHUT)};
            ACC_REFCLK: rdata_q <= {16'd0, cal_ref_period};
            ACC_CRS:    rdata_q <= {cal_coarse_delay, cal_coarse_ref};
            ACC_FIN:    rdata_q <= {cal_fine_delay, cal_fine_ref};
            ACC_PIN:    rdata_q <= rword;
            default:    rdata_q <= '0;
         endcase
      end
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/dlyreg_bank_chk.sv
module dlyreg_bank_chk #(
   parameter int unsigned NUM_PINS = 276,
   parameter int unsigned ADDR_W   = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic                  rd_en,
   input logic [ADDR_W-1:0]     addr,
   input logic [31:0]           wdata,
   input logic [31:0]           rdata,
   input logic [NUM_PINS*5-1:0] pin_coarse,
   input logic [NUM_PINS*5-1:0] pin_fine,
   input logic                  lock_open,
   input logic                  err_q
);
   localparam logic [31:0] LAST_PIN = 32'('h30 + 12*NUM_PINS - 4);

   logic [31:0] a32;
   logic        aligned;
   logic        lock_hit;
   logic        pin_hit;
   logic        beyond;
   logic        bad_sig;

   assign a32      = 32'(addr);
   assign aligned  = (a32[1:0] == 2'b00);
   assign lock_hit = wr_en && a32 == 32'h2C;
   assign pin_hit  = wr_en && aligned && a32 >= 32'h30 && a32 <= LAST_PIN;
   assign beyond   = !aligned || a32 > LAST_PIN;
   assign bad_sig  = wdata[17:12] != 6'h29;

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!lock_open && !err_q && pin_coarse == '0 && pin_fine == '0));

   assert_key_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_hit && wdata[15:0] == 16'hAAAA) |=> lock_open);

   assert_key_shut_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_hit && wdata[15:0] == 16'hAAAB) |=> !lock_open);

   assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_hit && wdata[15:0] != 16'hAAAA && wdata[15:0] != 16'hAAAB) |=> $stable(lock_open));

   assert_locked_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_hit && !lock_open) |=> ($stable(pin_coarse) && $stable(pin_fine)));

   assert_bad_sig_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_hit && bad_sig) |=> ($stable(pin_coarse) && $stable(pin_fine)));

   assert_err_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_hit && (!lock_open || bad_sig)) |=> err_q);

   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && beyond) |=> (rdata == 32'd0));

   assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

bind dlyreg_bank dlyreg_bank_chk #(
   .NUM_PINS (NUM_PINS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .addr       (addr),
   .wdata      (wdata),
   .rdata      (rdata),
   .pin_coarse (pin_coarse),
   .pin_fine   (pin_fine),
   .lock_open  (lock_open),
   .err_q      (err_q)
);

// File: tb/dlyreg_bank_tb.sv
`timescale 1ns/1ps
module dlyreg_bank_tb;
   localparam int NP = 276;
   localparam int AW = 12;
   localparam int NW = NP * 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic           rd_en = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic [31:0]    wdata = '0;
   logic [31:0]    rdata;
   logic [15:0]    cal_ref_period = 16'h0000;
   logic [15:0]    cal_coarse_delay = 16'h0000;
   logic [15:0]    cal_coarse_ref = 16'h0000;
   logic [15:0]    cal_fine_delay = 16'h0000;
   logic [15:0]    cal_fine_ref = 16'h0000;
   logic [NP*5-1:0] pin_coarse;
   logic [NP*5-1:0] pin_fine;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   logic [31:0] model [NW];

   always #4 clk = ~clk;

   dlyreg_bank #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
      .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
      .cal_ref_period, .cal_coarse_delay, .cal_coarse_ref,
      .cal_fine_delay, .cal_fine_ref, .pin_coarse, .pin_fine
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input int a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   function automatic int pin_off(input int p, input int s);
      return 'h30 + 12*p + 4*s;
   endfunction

   function automatic logic [31:0] pat(input int p, input int s);
      logic [31:0] v;
      v = (32'(p*4 + s) << 18) | (32'h29 << 12) | 32'((p*37 + s*11 + 5) & 'h7FF);
      return v;
   endfunction

   task automatic check_pin_outs(input string req);
      for (int p = 0; p < NP; p++) begin
         chk(req, 32'(pin_coarse[p*5 +: 5]), 32'((model[p*3] >> 5) & 'h1F));
         chk(req, 32'(pin_fine[p*5 +: 5]), 32'(model[p*3] & 'h1F));
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NW; i++) model[i] = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] rv;
      logic [31:0] held;
      do_reset();

      // R1 reset state
      bus_rd('h2C, rv); chk("R1 lock word after reset", rv, 32'h0000AAAB);
      chk("R1 coarse outputs zero", 32'(pin_coarse != '0), 32'd0);
      chk("R1 fine outputs zero", 32'(pin_fine != '0), 32'd0);
      bus_rd(pin_off(0, 0), rv); chk("R1 pin word zero", rv, 32'd0);

      // R9 unmapped reads
      for (int a = 0; a <= 'h10; a += 4) begin
         bus_rd(a, rv); chk("R9 reserved low read", rv, 32'd0);
      end
      for (int a = 'h20; a <= 'h28; a += 4) begin
         bus_rd(a, rv); chk("R9 reserved mid read", rv, 32'd0);
      end
      bus_rd('hD20, rv); chk("R9 beyond last pin read", rv, 32'd0);
      bus_rd('hFFC, rv); chk("R9 top offset read", rv, 32'd0);
      bus_rd('h31, rv);  chk("R9 misaligned read", rv, 32'd0);

      // R2 open the bank
      bus_wr('h2C, 32'h1234AAAA);
      bus_rd('h2C, rv); chk("R2 open key read", rv, 32'h0000AAAA);

      // R9 writes to unmapped offsets while open leave state and error alone
      bus_wr('hD20, 32'h00029123);
      bus_wr('h32, 32'h000293FF);
      bus_wr('h08, 32'h000293FF);
      bus_rd(pin_off(0, 0), rv); chk("R9 misaligned write ignored", rv, 32'd0);
      bus_rd('h2C, rv); chk("R9 no error from unmapped write", rv, 32'h0000AAAA);
      chk("R9 outputs unchanged", 32'(pin_coarse != '0 || pin_fine != '0), 32'd0);

      // R8 calibration readback, writes ignored
      cal_ref_period = 16'h1A2B; cal_coarse_delay = 16'h0345; cal_coarse_ref = 16'h6789;
      cal_fine_delay = 16'hBCDE; cal_fine_ref = 16'h0F01;
      bus_rd('h14, rv); chk("R8 period read", rv, 32'h00001A2B);
      bus_rd('h18, rv); chk("R8 coarse cal read", rv, 32'h03456789);
      bus_rd('h1C, rv); chk("R8 fine cal read", rv, 32'hBCDE0F01);
      bus_wr('h18, 32'hFFFFFFFF);
      bus_wr('h14, 32'h00029FFF);
      bus_rd('h18, rv); chk("R8 coarse cal after write", rv, 32'h03456789);
      bus_rd('h14, rv); chk("R8 period after write", rv, 32'h00001A2B);
      bus_rd('h2C, rv); chk("R8 no error from cal write", rv, 32'h0000AAAA);

      // R3 non-key values
      bus_wr('h2C, 32'h00005555);
      bus_rd('h2C, rv); chk("R3 open kept on 5555", rv, 32'h0000AAAA);
      bus_wr('h2C, 32'h0000AAAC);
      bus_rd('h2C, rv); chk("R3 open kept on AAAC", rv, 32'h0000AAAA);
      bus_wr('h2C, 32'hFFFFAAAB);
      bus_rd('h2C, rv); chk("R2 lock key read", rv, 32'h0000AAAB);
      bus_wr('h2C, 32'h0000ABAB);
      bus_rd('h2C, rv); chk("R3 locked kept on ABAB", rv, 32'h0000AAAB);

      // R5 R6 write while locked
      bus_wr(pin_off(5, 0), pat(5, 0));
      bus_rd(pin_off(5, 0), rv); chk("R5 locked write ignored", rv, 32'd0);
      chk("R5 locked outputs unchanged", 32'(pin_coarse[25 +: 5]), 32'd0);
      bus_rd('h2C, rv); chk("R6 error after locked write", rv, 32'h8000AAAB);

      // R4 R7 full sweep while open
      bus_wr('h2C, 32'h0000AAAA);
      bus_rd('h2C, rv); chk("R6 error stays after unlock", rv, 32'h8000AAAA);
      for (int p = 0; p < NP; p++) begin
         for (int s = 0; s < 3; s++) begin
            bus_wr(pin_off(p, s), pat(p, s));
            model[p*3 + s] = pat(p, s);
         end
      end
      for (int i = 0; i < NW; i++) begin
         bus_rd('h30 + 4*i, rv); chk("R4 sweep readback", rv, model[i]);
      end
      bus_rd('hD1C, rv); chk("R4 last word at D1C", rv, pat(NP-1, 2));
      check_pin_outs("R7 pin outputs after sweep");

      // R7 lock bit stored, outputs follow count fields; update on write edge
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(pin_off(7, 0)); wdata = 32'h000297FF;
      @(negedge clk);
      wr_en = 1'b0;
      model[21] = 32'h000297FF;
      chk("R7 coarse updates on write edge", 32'(pin_coarse[35 +: 5]), 32'h1F);
      chk("R7 fine updates on write edge", 32'(pin_fine[35 +: 5]), 32'h1F);
      bus_rd(pin_off(7, 0), rv); chk("R7 lock bit stored", rv, 32'h000297FF);

      // R5 bad signature
      bus_wr(pin_off(3, 0), 32'h0002A3FF);
      bus_wr(pin_off(3, 1), 32'h00000000);
      bus_rd(pin_off(3, 0), rv); chk("R5 bad signature ignored", rv, model[9]);
      bus_rd(pin_off(3, 1), rv); chk("R5 bad signature aux ignored", rv, model[10]);
      check_pin_outs("R5 outputs after bad signature");

      // R5 locked again
      bus_wr('h2C, 32'h0000AAAB);
      bus_wr(pin_off(NP-1, 0), 32'h00029000);
      bus_rd(pin_off(NP-1, 0), rv); chk("R5 locked last pin ignored", rv, model[(NP-1)*3]);

      // R10 read data holds until next read
      bus_rd(pin_off(2, 1), held);
      chk("R10 read value", held, model[7]);
      bus_wr('h2C, 32'h0000AAAA);
      bus_wr(pin_off(2, 1), 32'h00029ABC);
      repeat (3) @(negedge clk);
      chk("R10 rdata held without read", rdata, held);
      bus_rd(pin_off(2, 1), rv); chk("R10 new read value", rv, 32'h00029ABC);

      // R1 R6 reset clears state
      do_reset();
      bus_rd('h2C, rv); chk("R6 reset clears error", rv, 32'h0000AAAB);
      bus_rd(pin_off(7, 0), rv); chk("R1 pin word zero after reset", rv, 32'd0);
      check_pin_outs("R1 outputs after reset");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule